// File: doc/BRIEF.md
# Two-Wide Register Rename Unit

This block maps architectural register numbers to physical register tags for up to two decoded instructions per cycle, feeding an out-of-order core that keeps every value, committed or speculative, in one physical register file. It keeps three pieces of state: a speculative map that holds the newest mapping for each architectural register, a committed map that holds the mapping retired so far, and a free mask over the physical registers. No register data passes through the block.

In each cycle the decode stage presents two slots. Slot 0 is the older one. The unit returns the physical tags of the sources and a freshly allocated destination tag. It also returns the mapping that the destination replaces, so that the reorder buffer can keep it until the instruction retires. When the instruction retires, the commit port writes its mapping into the committed map and returns the replaced register to the free mask. A flush discards all speculative work. It copies the committed map over the speculative one and rebuilds the free mask from the committed map alone. Architectural register 0 always reads as physical register 0 and is never renamed.

A slot-1 source that names the destination slot 0 writes in the same cycle takes slot 0's new tag. When both slots write the same architectural register, slot 1's mapping is the one that remains in the table.

Top module: `reg_rename2`

## Requirements
- R1: After reset, architectural register i maps to physical register i in both maps, and physical registers 32 to 63 are free. The first register allocated is 32.
- R2: A source tag is the speculative mapping of its architectural register, including the updates from earlier cycles. Architectural register 0 always gives tag 0.
- R3: A slot allocates only if it is valid, writes a register and names a destination other than 0. The first allocating slot gets the lowest-numbered free register. If both slots allocate, slot 1 gets the next lowest. A new tag is never 0 and never equals the previous tag it returns.
- R4: A slot-1 source whose register equals the destination of an allocating slot 0 takes slot 0's new tag in place of the table entry.
- R5: The previous tag is the speculative mapping of the destination before the cycle. If both slots allocate the same register, slot 1's previous tag is slot 0's new tag, and slot 1's mapping is the one kept.
- R6: Stall is high when fewer free registers exist than the slots need. In that case nothing is allocated and the speculative map does not change.
- R7: A commit writes its mapping into the committed map and frees its previous tag. The freed tag can be allocated from the next cycle onward.
- R8: On flush, a commit in the same cycle still applies. The speculative map then becomes the committed map, and the free mask becomes every nonzero register that the committed map does not reference. Renames in that cycle are dropped and stall stays low.
- R9: A slot that does not allocate (invalid, not writing, or destination 0) reports a destination tag of 0 and a previous tag of 0, and uses no free register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard speculative state |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_wr | input | 1 | Slot 0 writes a register |
| s0_rs1 | input | 5 | Slot 0 first source register |
| s0_rs2 | input | 5 | Slot 0 second source register |
| s0_rd | input | 5 | Slot 0 destination register |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_wr | input | 1 | Slot 1 writes a register |
| s1_rs1 | input | 5 | Slot 1 first source register |
| s1_rs2 | input | 5 | Slot 1 second source register |
| s1_rd | input | 5 | Slot 1 destination register |
| cmt_valid | input | 1 | A writer retires this cycle |
| cmt_rd | input | 5 | Retiring destination register |
| cmt_pdst | input | 6 | Retiring new tag |
| cmt_pprev | input | 6 | Retiring previous tag, to be freed |
| stall | output | 1 | Not enough free registers, decode must hold |
| s0_ps1 | output | 6 | Slot 0 first source tag |
| s0_ps2 | output | 6 | Slot 0 second source tag |
| s0_pdst | output | 6 | Slot 0 new destination tag |
| s0_pprev | output | 6 | Slot 0 previous destination tag |
| s1_ps1 | output | 6 | Slot 1 first source tag |
| s1_ps2 | output | 6 | Slot 1 second source tag |
| s1_pdst | output | 6 | Slot 1 new destination tag |
| s1_pprev | output | 6 | Slot 1 previous destination tag |

## Verification
A wrong speculative map entry shows up in the first later cycle that reads that register as a source or destination, as a source or previous tag that differs from the expected one. A register that leaks from the free mask, or is freed twice, changes the order of allocation. The new tags then drift from the expected lowest-free sequence within a few allocations, and stall rises early or late once the pool runs dry. A wrong committed map stays hidden until the next flush. Right after the flush, every source tag and the rebuilt allocation order expose it, which is why the stimulus flushes often.

// File: rtl/ren_pkg.sv
package ren_pkg;
    parameter int NARCH = 32;
    parameter int NPHYS = 64;
    localparam int AW = $clog2(NARCH);
    localparam int PW = $clog2(NPHYS);
    localparam int NRD = 6;

    typedef logic [AW-1:0] arch_t;
    typedef logic [PW-1:0] phys_t;

    typedef struct packed {
        logic  valid;
        logic  wr;
        arch_t rs1;
        arch_t rs2;
        arch_t rd;
    } slot_req_t;

    typedef struct packed {
        phys_t ps1;
        phys_t ps2;
        phys_t pdst;
        phys_t pprev;
    } slot_rsp_t;

    function automatic logic needs_reg(slot_req_t s);
        return s.valid && s.wr && (s.rd != '0);
    endfunction
endpackage

// File: rtl/ren_map_table.sv
module ren_map_table
    import ren_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  we0,
    input  arch_t                 wa0,
    input  phys_t                 wd0,
    input  logic                  we1,
    input  arch_t                 wa1,
    input  phys_t                 wd1,
    input  logic                  cmt_we,
    input  arch_t                 cmt_wa,
    input  phys_t                 cmt_wd,
    input  arch_t [NRD-1:0]       raddr,
    output phys_t [NRD-1:0]       rdata,
    output phys_t [NARCH-1:0]     cmt_next
);
    phys_t [NARCH-1:0] spec_q;
    phys_t [NARCH-1:0] cmt_q;

    always_comb begin
        cmt_next = cmt_q;
        if (cmt_we && cmt_wa != '0)
            cmt_next[cmt_wa] = cmt_wd;
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r] = spec_q[raddr[r]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < NARCH; a++) begin
                spec_q[a] <= PW'(a);
                cmt_q[a]  <= PW'(a);
            end
        end else begin
            cmt_q <= cmt_next;
            if (flush) begin
                spec_q <= cmt_next;
            end else begin
                if (we0 && wa0 != '0) spec_q[wa0] <= wd0;
                if (we1 && wa1 != '0) spec_q[wa1] <= wd1;
            end
        end
    end
endmodule

// File: rtl/ren_free_list.sv
module ren_free_list
    import ren_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              take0,
    input  logic              take1,
    input  logic              rel_en,
    input  phys_t             rel_tag,
    input  phys_t [NARCH-1:0] cmt_map,
    output logic              have0,
    output logic              have1,
    output phys_t             pick0,
    output phys_t             pick1
);
    logic [NPHYS-1:0] free_q;
    logic [NPHYS-1:0] rest;
    logic [NPHYS-1:0] rebuilt;

    always_comb begin
        have0 = 1'b0;
        pick0 = '0;
        for (int p = NPHYS - 1; p > 0; p--) begin
            if (free_q[p]) begin
                have0 = 1'b1;
                pick0 = PW'(p);
            end
        end
        rest = free_q;
        rest[pick0] = 1'b0;
        have1 = 1'b0;
        pick1 = '0;
        for (int p = NPHYS - 1; p > 0; p--) begin
            if (rest[p]) begin
                have1 = have0;
                pick1 = PW'(p);
            end
        end
    end

    for (genvar p = 0; p < NPHYS; p++) begin : g_rebuild
        logic used;
        always_comb begin
            used = (p == 0);
            for (int a = 0; a < NARCH; a++)
                if (cmt_map[a] == PW'(p)) used = 1'b1;
        end
        assign rebuilt[p] = ~used;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPHYS; p++)
                free_q[p] <= (p >= NARCH);
        end else if (flush) begin
            free_q <= rebuilt;
        end else begin
            if (take0) free_q[pick0] <= 1'b0;
            if (take1) free_q[pick1] <= 1'b0;
            if (rel_en && rel_tag != '0) free_q[rel_tag] <= 1'b1;
        end
    end
endmodule

// File: rtl/ren_intra_dep.sv
module ren_intra_dep
    import ren_pkg::*;
(
    input  logic  older_alloc,
    input  arch_t older_rd,
    input  phys_t older_pdst,
    input  arch_t young_rs1,
    input  arch_t young_rs2,
    input  arch_t young_rd,
    input  phys_t tbl_rs1,
    input  phys_t tbl_rs2,
    input  phys_t tbl_rd,
    output phys_t young_ps1,
    output phys_t young_ps2,
    output phys_t young_prev
);
    logic hit1, hit2, hitd;

    assign hit1 = older_alloc && (young_rs1 == older_rd);
    assign hit2 = older_alloc && (young_rs2 == older_rd);
    assign hitd = older_alloc && (young_rd == older_rd);

    assign young_ps1  = hit1 ? older_pdst : tbl_rs1;
    assign young_ps2  = hit2 ? older_pdst : tbl_rs2;
    assign young_prev = hitd ? older_pdst : tbl_rd;
endmodule

// File: rtl/reg_rename2.sv
module reg_rename2
    import ren_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  s0_valid,
    input  logic  s0_wr,
    input  logic [4:0] s0_rs1,
    input  logic [4:0] s0_rs2,
    input  logic [4:0] s0_rd,
    input  logic  s1_valid,
    input  logic  s1_wr,
    input  logic [4:0] s1_rs1,
    input  logic [4:0] s1_rs2,
    input  logic [4:0] s1_rd,
    input  logic  cmt_valid,
    input  logic [4:0] cmt_rd,
    input  logic [5:0] cmt_pdst,
    input  logic [5:0] cmt_pprev,
    output logic  stall,
    output logic [5:0] s0_ps1,
    output logic [5:0] s0_ps2,
    output logic [5:0] s0_pdst,
    output logic [5:0] s0_pprev,
    output logic [5:0] s1_ps1,
    output logic [5:0] s1_ps2,
    output logic [5:0] s1_pdst,
    output logic [5:0] s1_pprev
);
    slot_req_t q0, q1;
    slot_rsp_t r0, r1;
    logic need0, need1, enough, fire;
    logic have0, have1, take0, take1;
    phys_t pick0, pick1;
    arch_t [NRD-1:0] raddr;
    phys_t [NRD-1:0] rdata;
    phys_t [NARCH-1:0] cmt_map;
    phys_t s1_prev_raw;

    assign q0 = '{valid: s0_valid, wr: s0_wr, rs1: s0_rs1, rs2: s0_rs2, rd: s0_rd};
    assign q1 = '{valid: s1_valid, wr: s1_wr, rs1: s1_rs1, rs2: s1_rs2, rd: s1_rd};

    assign need0 = needs_reg(q0);
    assign need1 = needs_reg(q1);

    always_comb begin
        unique case ({need0, need1})
            2'b11:   enough = have1;
            2'b10,
            2'b01:   enough = have0;
            default: enough = 1'b1;
        endcase
    end

    assign fire  = !flush && enough;
    assign stall = !flush && !enough;
    assign take0 = fire && (need0 || need1);
    assign take1 = fire && need0 && need1;

    assign raddr = {q1.rd, q1.rs2, q1.rs1, q0.rd, q0.rs2, q0.rs1};

    ren_map_table u_map (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .we0     (fire && need0),
        .wa0     (q0.rd),
        .wd0     (r0.pdst),
        .we1     (fire && need1),
        .wa1     (q1.rd),
        .wd1     (r1.pdst),
        .cmt_we  (cmt_valid),
        .cmt_wa  (cmt_rd),
        .cmt_wd  (cmt_pdst),
        .raddr   (raddr),
        .rdata   (rdata),
        .cmt_next(cmt_map)
    );

    ren_free_list u_free (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .take0  (take0),
        .take1  (take1),
        .rel_en (cmt_valid),
        .rel_tag(cmt_pprev),
        .cmt_map(cmt_map),
        .have0  (have0),
        .have1  (have1),
        .pick0  (pick0),
        .pick1  (pick1)
    );

    always_comb begin
        r0.ps1   = rdata[0];
        r0.ps2   = rdata[1];
        r0.pdst  = need0 ? pick0 : '0;
        r0.pprev = need0 ? rdata[2] : '0;
        r1.pdst  = need1 ? (need0 ? pick1 : pick0) : '0;
        r1.pprev = need1 ? s1_prev_raw : '0;
    end

    ren_intra_dep u_dep (
        .older_alloc(need0),
        .older_rd   (q0.rd),
        .older_pdst (r0.pdst),
        .young_rs1  (q1.rs1),
        .young_rs2  (q1.rs2),
        .young_rd   (q1.rd),
        .tbl_rs1    (rdata[3]),
        .tbl_rs2    (rdata[4]),
        .tbl_rd     (rdata[5]),
        .young_ps1  (r1.ps1),
        .young_ps2  (r1.ps2),
        .young_prev (s1_prev_raw)
    );

    assign s0_ps1   = r0.ps1;
    assign s0_ps2   = r0.ps2;
    assign s0_pdst  = r0.pdst;
    assign s0_pprev = r0.pprev;
    assign s1_ps1   = r1.ps1;
    assign s1_ps2   = r1.ps2;
    assign s1_pdst  = r1.pdst;
    assign s1_pprev = r1.pprev;
endmodule

// File: rtl/ren_checker.sv
module ren_checker (
    input logic       clk,
    input logic       rst,
    input logic       flush,
    input logic       stall,
    input logic       s0_valid,
    input logic       s0_wr,
    input logic [4:0] s0_rs1,
    input logic [4:0] s0_rd,
    input logic       s1_valid,
    input logic       s1_wr,
    input logic [4:0] s1_rs1,
    input logic [4:0] s1_rd,
    input logic [5:0] s0_ps1,
    input logic [5:0] s0_pdst,
    input logic [5:0] s0_pprev,
    input logic [5:0] s1_ps1,
    input logic [5:0] s1_pdst,
    input logic [5:0] s1_pprev
);
    logic a0, a1;
    assign a0 = s0_valid && s0_wr && (s0_rd != 5'd0);
    assign a1 = s1_valid && s1_wr && (s1_rd != 5'd0);

    AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (s0_rs1 == 5'd0) |-> (s0_ps1 == 6'd0)); // R2
    AST_NEW_NOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (a0 && !stall && !flush) |-> (s0_pdst != 6'd0 && s0_pdst != s0_pprev)); // R3
    AST_DISTINCT_NEW: assert property (@(posedge clk) disable iff (rst)
        (a0 && a1 && !stall && !flush) |-> (s0_pdst != s1_pdst)); // R3
    AST_SAME_CYCLE_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (a0 && s1_rs1 == s0_rd) |-> (s1_ps1 == s0_pdst)); // R4
    AST_WAW_PREV: assert property (@(posedge clk) disable iff (rst)
        (a0 && a1 && s1_rd == s0_rd) |-> (s1_pprev == s0_pdst)); // R5
    AST_FLUSH_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        flush |-> !stall); // R8
    AST_IDLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !a0 |-> (s0_pdst == 6'd0 && s0_pprev == 6'd0)); // R9
endmodule

bind reg_rename2 ren_checker u_chk (
    .clk(clk), .rst(rst), .flush(flush), .stall(stall),
    .s0_valid(s0_valid), .s0_wr(s0_wr), .s0_rs1(s0_rs1), .s0_rd(s0_rd),
    .s1_valid(s1_valid), .s1_wr(s1_wr), .s1_rs1(s1_rs1), .s1_rd(s1_rd),
    .s0_ps1(s0_ps1), .s0_pdst(s0_pdst), .s0_pprev(s0_pprev),
    .s1_ps1(s1_ps1), .s1_pdst(s1_pdst), .s1_pprev(s1_pprev)
);

// File: tb/tb_reg_rename2.sv
module tb_reg_rename2;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic s0_valid = 1'b0, s0_wr = 1'b0, s1_valid = 1'b0, s1_wr = 1'b0;
    logic [4:0] s0_rs1 = '0, s0_rs2 = '0, s0_rd = '0;
    logic [4:0] s1_rs1 = '0, s1_rs2 = '0, s1_rd = '0;
    logic cmt_valid = 1'b0;
    logic [4:0] cmt_rd = '0;
    logic [5:0] cmt_pdst = '0, cmt_pprev = '0;
    logic stall;
    logic [5:0] s0_ps1, s0_ps2, s0_pdst, s0_pprev, s1_ps1, s1_ps2, s1_pdst, s1_pprev;

    always #10 clk = ~clk;

    reg_rename2 dut (.*);

    int spec_m [32];
    int cmt_m [32];
    bit free_m [64];
    int fq_rd [128];
    int fq_new [128];
    int fq_old [128];
    int fq_head = 0;
    int fq_tail = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int low_free(int skip);
        for (int p = 1; p < 64; p++)
            if (free_m[p] && p != skip) return p;
        return -1;
    endfunction

    function automatic int count_free();
        int n = 0;
        for (int p = 1; p < 64; p++) if (free_m[p]) n++;
        return n;
    endfunction

    task automatic model_reset();
        for (int a = 0; a < 32; a++) begin spec_m[a] = a; cmt_m[a] = a; end
        for (int p = 0; p < 64; p++) free_m[p] = (p >= 32);
        fq_head = 0; fq_tail = 0;
    endtask

    // drive one cycle; inputs set at negedge, outputs checked before next posedge
    task automatic step(bit v0, bit w0, int a1, int a2, int d0,
                        bit v1, bit w1, int b1, int b2, int d1,
                        bit do_cmt, bit do_flush);
        bit n0, n1, st;
        int e0d, e1d, e0p, e1p, e1s1, e1s2, crd, cnew, cold;
        @(negedge clk);
        s0_valid = v0; s0_wr = w0; s0_rs1 = 5'(a1); s0_rs2 = 5'(a2); s0_rd = 5'(d0);
        s1_valid = v1; s1_wr = w1; s1_rs1 = 5'(b1); s1_rs2 = 5'(b2); s1_rd = 5'(d1);
        do_cmt = do_cmt && (fq_head != fq_tail);
        crd = 0; cnew = 0; cold = 0;
        if (do_cmt) begin
            crd = fq_rd[fq_head % 128]; cnew = fq_new[fq_head % 128]; cold = fq_old[fq_head % 128];
        end
        cmt_valid = do_cmt; cmt_rd = 5'(crd); cmt_pdst = 6'(cnew); cmt_pprev = 6'(cold);
        flush = do_flush;
        n0 = v0 && w0 && d0 != 0;
        n1 = v1 && w1 && d1 != 0;
        st = !do_flush && (count_free() < (int'(n0) + int'(n1)));
        e0d = n0 ? low_free(-1) : 0;
        e1d = n1 ? (n0 ? low_free(e0d) : low_free(-1)) : 0;
        e0p = n0 ? spec_m[d0] : 0;
        e1p = n1 ? ((n0 && d1 == d0) ? e0d : spec_m[d1]) : 0;
        e1s1 = (n0 && b1 == d0) ? e0d : spec_m[b1];
        e1s2 = (n0 && b2 == d0) ? e0d : spec_m[b2];
        #2;
        chk(do_flush ? "R8 stall" : "R6 stall", int'(stall), int'(st));
        if (!st && !do_flush) begin
            if (v0) begin
                chk("R2 s0_ps1", s0_ps1, spec_m[a1]);
                chk("R2 s0_ps2", s0_ps2, spec_m[a2]);
            end
            chk(n0 ? "R3 s0_pdst" : "R9 s0_pdst", s0_pdst, e0d);
            chk(n0 ? "R5 s0_pprev" : "R9 s0_pprev", s0_pprev, e0p);
            if (v1) begin
                chk("R4 s1_ps1", s1_ps1, e1s1);
                chk("R4 s1_ps2", s1_ps2, e1s2);
            end
            chk(n1 ? "R3 s1_pdst" : "R9 s1_pdst", s1_pdst, e1d);
            chk(n1 ? "R5 s1_pprev" : "R9 s1_pprev", s1_pprev, e1p);
        end
        // model update
        if (do_cmt) begin
            fq_head++;
            cmt_m[crd] = cnew;
        end
        if (do_flush) begin
            for (int a = 0; a < 32; a++) spec_m[a] = cmt_m[a];
            for (int p = 0; p < 64; p++) free_m[p] = (p != 0);
            for (int a = 0; a < 32; a++) free_m[cmt_m[a]] = 1'b0;
            fq_head = 0; fq_tail = 0;
        end else begin
            if (!st) begin
                if (n0) begin
                    free_m[e0d] = 1'b0; spec_m[d0] = e0d;
                    fq_rd[fq_tail % 128] = d0; fq_new[fq_tail % 128] = e0d; fq_old[fq_tail % 128] = e0p;
                    fq_tail++;
                end
                if (n1) begin
                    free_m[e1d] = 1'b0; spec_m[d1] = e1d;
                    fq_rd[fq_tail % 128] = d1; fq_new[fq_tail % 128] = e1d; fq_old[fq_tail % 128] = e1p;
                    fq_tail++;
                end
            end
            if (do_cmt) free_m[cold] = 1'b1;
        end
    endtask

    function automatic int rarch();
        return ($urandom % 2 == 0) ? int'($urandom % 4) : int'($urandom % 32);
    endfunction

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: reset state, first allocation is 32, identity sources
        step(1, 1, 7, 0, 5, 1, 0, 5, 9, 0, 0, 0);
        chk("R1 first tag", 32, 32);
        // R4/R5: same destination both slots, source bypass
        step(1, 1, 5, 5, 3, 1, 1, 3, 5, 3, 0, 0);
        // R9: writes to register 0 allocate nothing
        step(1, 1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
        // R6: exhaust the pool without commits
        for (int i = 0; i < 18; i++) step(1, 1, i % 32, 1, (i % 31) + 1, 1, 1, 2, 3, ((i + 7) % 31) + 1, 0, 0);
        // R8: flush with empty committed history restores identity
        step(1, 1, 1, 2, 3, 1, 1, 4, 5, 6, 0, 1);
        step(1, 1, 3, 6, 9, 0, 0, 0, 0, 0, 0, 0);
        chk("R8 restore", int'(s0_ps1), 3);
        // R7: commit frees, then random mix
        for (int i = 0; i < 3000; i++) begin
            bit v0, w0, v1, w1, c, f;
            v0 = ($urandom % 8) != 0; w0 = ($urandom % 4) != 0;
            v1 = ($urandom % 8) != 0; w1 = ($urandom % 4) != 0;
            c = ($urandom % 3) != 0;
            f = ($urandom % 60) == 0;
            step(v0, w0, rarch(), rarch(), rarch(), v1, w1, rarch(), rarch(), rarch(), c, f);
        end
        // R7/R8: commit a pending writer then flush in the same cycle
        step(1, 1, 1, 1, 4, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        step(1, 0, 4, 4, 0, 0, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule